// File: doc/BRIEF.md
# Saturating Up-Counter With Runtime Limit

This block is a synchronous up-counter whose ceiling arrives on an input port rather than being fixed at build time. After reset it starts from zero and advances by one on each rising clock edge. When the count reaches the ceiling it stops and keeps that value on every later edge until reset is applied again.

The count is stored in a separate D-register submodule. A combinational step stage decides whether to advance or hold. That stage classifies the present situation into one of two phases, and the phase picks the next value:

- RUN: count < limit, so the next value is count + 1.
- PARK: count >= limit, so the next value equals the present count.

The transition RUN->PARK happens when the count catches up with the limit. The transition PARK->RUN happens only when the limit is raised above a held count. Reset returns the register to zero from either phase. The limit may change at any time. A limit below the present count parks the counter and never makes it wrap or step back. The count width is the parameter `WIDTH`, which defaults to 3 bits, and the limit uses the same width.

Top module: `satcnt`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `count` is 0 after that edge, whatever its previous value and whatever `limit` is.
- R2: When `rst` is low and `count` < `limit` (unsigned) at a rising edge, `count` becomes its previous value plus one after that edge.
- R3: When `rst` is low and `count` == `limit` at a rising edge, `count` keeps its value after that edge.
- R4: When `rst` is low and `limit` < `count` at a rising edge, `count` keeps its value after that edge. It does not wrap and does not decrease.
- R5: With `limit` held at 0 after reset, `count` stays at 0 on every edge.
- R6: With `limit` at the all-ones value, `count` climbs to all-ones and stays there. It never overflows to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| limit | input | WIDTH | Runtime ceiling for the count, unsigned |
| count | output | WIDTH | Present count value, registered |

## Verification
The assertions assume that `rst` is driven to a known level from the first clock edge. Before any edge, `count` has no defined value, so each clocked property is disabled while reset is high. The assertions also assume that `limit` is stable around each rising edge. The bench meets both assumptions: it holds reset high from time zero and changes `rst` and `limit` only at falling edges. During a run the bench moves `limit` up, down, to zero and to all-ones, so that both phases and both transitions between them are exercised.

// File: rtl/satcnt_pkg.sv
package satcnt_pkg;

    // Decision phase of the step logic
    typedef enum logic {
        PH_RUN  = 1'b0,   // count below limit: advance
        PH_PARK = 1'b1    // count at or above limit: hold
    } phase_e;

endpackage

// File: rtl/satcnt_dreg.sv
module satcnt_dreg #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] RST_VAL = '0;

    // Storage element with synchronous active-high reset
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
    end

endmodule

// File: rtl/satcnt_step.sv
module satcnt_step
    import satcnt_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] lim,
    output logic [WIDTH-1:0] nxt,
    output phase_e           phase
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Classify the present situation
    always_comb begin
        phase = (cur < lim) ? PH_RUN : PH_PARK;
    end

    // Next value selected by phase
    always_comb begin
        unique case (phase)
            PH_RUN:  nxt = cur + ONE;
            PH_PARK: nxt = cur;
            default: nxt = cur;
        endcase
    end

    // Advancing is only chosen when it cannot overflow
    always_comb begin
        if (phase == PH_RUN) begin
            a_r6_step_no_wrap: assert (nxt != '0);
        end
    end

endmodule

// File: rtl/satcnt.sv
module satcnt
    import satcnt_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    logic [WIDTH-1:0] count_next;
    phase_e           phase;

    satcnt_step #(.WIDTH(WIDTH)) u_step (
        .cur   (count),
        .lim   (limit),
        .nxt   (count_next),
        .phase (phase)
    );

    satcnt_dreg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (count_next),
        .q   (count)
    );

    // R2: below the limit the count advances by exactly one
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (count < limit) |=> (count == $past(count) + ONE));

    // R3: at the limit the count holds
    a_r3_hold_at_limit: assert property (@(posedge clk) disable iff (rst)
        (count == limit) |=> $stable(count));

    // R4: a limit below the count never moves it
    a_r4_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (limit < count) |=> $stable(count));

    // R5: a zero limit keeps the count at zero
    a_r5_zero_limit: assert property (@(posedge clk) disable iff (rst)
        (limit == '0 && count == '0) |=> (count == '0));

    // R6: the all-ones value is never exceeded
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (count == ALL_ONES) |=> (count == ALL_ONES));

endmodule

// File: tb/sim_satcnt.sv
module sim_satcnt;

    localparam int WIDTH = 3;
    localparam int MAXV  = (1 << WIDTH) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] limit = '0;
    logic [WIDTH-1:0] count;

    int checks   = 0;
    int failures = 0;
    int model    = 0;
    bit done     = 0;

    satcnt #(.WIDTH(WIDTH)) u0 (
        .clk   (clk),
        .rst   (rst),
        .limit (limit),
        .count (count)
    );

    always #4 clk = ~clk;   // 125 MHz

    // One clock: apply inputs at the falling edge, update the model
    // at the rising edge, compare at the next falling edge.
    task automatic step(input bit r, input int lim, input string req);
        rst   = r;
        limit = lim[WIDTH-1:0];
        @(posedge clk);
        if (r)               model = 0;
        else if (model < lim) model = model + 1;
        @(negedge clk);
        checks++;
        if (int'(count) !== model) begin
            failures++;
            $display("FAIL %s: count=%0d expected=%0d (limit=%0d rst=%0b)",
                     req, count, model, lim, r);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        step(1, 3, "R1");
        step(1, 3, "R1");
        // R2, R3: limit 5 gives 0..5 then holds
        for (int i = 0; i < 5; i++) step(0, 5, "R2");
        for (int i = 0; i < 4; i++) step(0, 5, "R3");
        // R4: lower the limit below the held count
        for (int i = 0; i < 3; i++) step(0, 2, "R4");
        step(0, 0, "R4");
        // R2: raise it again, counting resumes
        for (int i = 0; i < 3; i++) step(0, 7, "R2");
        // R1: reset in the middle of a run
        step(1, 7, "R1");
        // R5: zero limit keeps zero
        for (int i = 0; i < 5; i++) step(0, 0, "R5");
        // R6: all-ones limit reached, no overflow
        for (int i = 0; i < MAXV + 4; i++) step(0, MAXV, "R6");
        // R4: lower limit while at all-ones
        for (int i = 0; i < 2; i++) step(0, 1, "R4");
        // R1: reset overrides everything
        step(1, MAXV, "R1");
        // R3: small limit of 1
        for (int i = 0; i < 4; i++) step(0, 1, "R3");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: count=%0d expected=finished run", count);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule